// File: doc/BRIEF.md
# Bypass-Chained Binary to Canonical Signed-Digit Recoder

This block recodes a binary word into canonical signed-digit (CSD) form, the signed-digit form in which no two neighbouring digits are both nonzero. CSD gives the smallest possible number of nonzero digits, and it is unique for each value. A constant or variable multiplier fed from it therefore needs the fewest partial products. The recoder is a row of identical digit slices. Each slice looks at a window of three neighbouring input bits and emits one digit. The digit is coded as a sign bit and a magnitude bit.

There is no carry chain. A single bypass bit travels from each slice to the next more significant one. When a slice emits a nonzero digit, it raises the bypass bit. The next slice then emits zero, whatever its input bits are, and lowers the bypass bit again so that the slice after it is free to decide.

The parameter `SIGNED_IN` selects between two input modes:
- Two's complement: there are `WIDTH` output digits, and the top bit is sign-extended.
- Unsigned: there is one extra digit, so that the largest values can be represented.

The recoding logic is combinational. When `OUT_REG` is 1, the digits are captured in an output register that is cleared by the active-low reset.

Top module: `csd_bypass_recoder`

## Requirements
- R1: Each digit is coded as {sign, magnitude}: 00 is zero, 01 is +1 and 11 is -1. The code 10 never appears on the outputs.
- R2: When a slice is not bypassed, its magnitude is b[i] XOR b[i-1] and its sign is b[i+1] AND magnitude. The triples (b[i+1],b[i],b[i-1]) 001 and 010 give +1, 101 and 110 give -1, and 000, 011, 100 and 111 give 0. The LSB slice uses b[-1]=0 and is never bypassed.
- R3: A slice that emits a nonzero digit forces the next more significant digit to zero, whatever that slice's input bits are. That forced-zero slice releases the slice above it.
- R4: No two adjacent digit positions are both nonzero, so at most ceil(D/2) digits are nonzero, where D is the number of output digits.
- R5: The sum of digit·2^i over all output digits equals the input value. The input is read as two's complement when SIGNED_IN=1 and as unsigned otherwise.
- R6: With SIGNED_IN=1 the outputs have WIDTH digits and b[WIDTH]=b[WIDTH-1]. An all-ones input gives a single -1 at position 0.
- R7: With SIGNED_IN=0 the outputs have WIDTH+1 digits and b[WIDTH]=b[WIDTH+1]=0. The input 2^WIDTH-1 gives +1 at position WIDTH and -1 at position 0.
- R8: With OUT_REG=1 the digits appear one clock after the input is presented. While rst_n is low, both output vectors are zero.
- R9: The 7-bit input 0101011 gives the digits +1,0,-1,0,-1,0,-1 from MSB to LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| bin_i | input | WIDTH | Binary word to recode |
| sign_o | output | WIDTH+1-SIGNED_IN | Sign bit of each digit, LSB digit at bit 0 |
| mag_o | output | WIDTH+1-SIGNED_IN | Magnitude bit of each digit, LSB digit at bit 0 |

## Verification
Every 8-bit input is applied to both a signed and an unsigned instance, and each output is compared digit by digit with a CSD computed in the bench by the classical right-to-left method. Because CSD is unique, any slip in the bypass chain, the window rule or the end padding shows up as a digit mismatch. Independently of that reference, each output is also checked for adjacent nonzero digits, for the forbidden 10 code, and for the value it sums to.

Directed words target specific behaviours:
- Alternating 01 runs give the longest possible bypass chain.
- Long runs of ones exercise the end-of-run -1 and +1 pair.
- The 0101011 word is checked.
- All-ones, most negative and largest unsigned inputs probe the sign extension and the extra digit.

A wide signed instance is driven with seeded random words. This shows that the chain still holds where exhaustive coverage is impossible.

// File: rtl/csd_bypass_recoder.sv
module csd_bypass_recoder #(
  parameter int WIDTH     = 16,
  parameter bit SIGNED_IN = 1'b1,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [WIDTH-1:0]                     bin_i,
  output logic [WIDTH-(SIGNED_IN ? 1 : 0):0]   sign_o,
  output logic [WIDTH-(SIGNED_IN ? 1 : 0):0]   mag_o
);

  localparam int NDIG = WIDTH + (SIGNED_IN ? 0 : 1);
  localparam int EXTW = NDIG + 2;
  localparam int VW   = NDIG + 2;
  localparam int MAXNZ = (NDIG + 1) / 2;

  // ext[k+1] holds b[k]; ext[0] is b[-1]
  logic [EXTW-1:0] ext;
  logic [NDIG-1:0] byp;
  logic [NDIG-1:0] dsign, dmag;

  generate
    if (SIGNED_IN) begin : g_sext
      assign ext = {bin_i[WIDTH-1], bin_i, 1'b0};
    end else begin : g_zext
      assign ext = {2'b00, bin_i, 1'b0};
    end
  endgenerate

  assign byp[0] = 1'b0;

  for (genvar i = 0; i < NDIG; i++) begin : g_slice
    logic diff;
    assign diff     = ext[i+1] ^ ext[i];
    assign dmag[i]  = diff & ~byp[i];
    assign dsign[i] = ext[i+2] & dmag[i];
    if (i < NDIG - 1) begin : g_chain
      assign byp[i+1] = ~(~diff | byp[i]);
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sign_o <= '0;
          mag_o  <= '0;
        end else begin
          sign_o <= dsign;
          mag_o  <= dmag;
        end
      end
    end else begin : g_comb
      assign sign_o = dsign;
      assign mag_o  = dmag;
    end
  endgenerate

  function automatic logic signed [VW-1:0] digit_sum(input logic [NDIG-1:0] s,
                                                     input logic [NDIG-1:0] m);
    logic signed [VW-1:0] acc;
    logic signed [VW-1:0] w;
    acc = '0;
    for (int k = 0; k < NDIG; k++) begin
      w = '0;
      w[k] = 1'b1;
      if (m[k]) acc = s[k] ? acc - w : acc + w;
    end
    return acc;
  endfunction

  logic signed [VW-1:0] in_val;
  assign in_val = {{(VW-WIDTH){SIGNED_IN && bin_i[WIDTH-1]}}, bin_i};

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sign_o & ~mag_o) == '0); // R1

  AST_NO_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_o & (mag_o >> 1)) == '0); // R4

  AST_WEIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mag_o) <= MAXNZ); // R4

  generate
    if (OUT_REG) begin : g_chk_reg
      AST_VALUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> digit_sum(sign_o, mag_o) == $past(in_val)); // R5
    end else begin : g_chk_comb
      AST_VALUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        digit_sum(sign_o, mag_o) == in_val); // R5
    end
  endgenerate

endmodule

// File: tb/csd_bypass_recoder_tb.sv
module csd_bypass_recoder_tb;

  localparam int NW = 8;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NW-1:0] bin_s, bin_u;
  logic [WW-1:0] bin_w;
  logic [NW-1:0] s_sign, s_mag;
  logic [NW:0]   u_sign, u_mag;
  logic [WW-1:0] w_sign, w_mag;

  int checks = 0;
  int errors = 0;

  csd_bypass_recoder #(.WIDTH(NW), .SIGNED_IN(1'b1), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bin_i(bin_s), .sign_o(s_sign), .mag_o(s_mag));

  csd_bypass_recoder #(.WIDTH(NW), .SIGNED_IN(1'b0), .OUT_REG(1'b1)) u_dut_uns (
    .clk(clk), .rst_n(rst_n), .bin_i(bin_u), .sign_o(u_sign), .mag_o(u_mag));

  csd_bypass_recoder #(.WIDTH(WW), .SIGNED_IN(1'b1), .OUT_REG(1'b1)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .bin_i(bin_w), .sign_o(w_sign), .mag_o(w_mag));

  // reference CSD by right-to-left recoding; returns {sign,mag} pairs packed as 64+64
  function automatic logic [127:0] ref_csd(input longint val);
    longint x;
    logic [63:0] s, m;
    x = val; s = '0; m = '0;
    for (int k = 0; k < 64; k++) begin
      if (x[0]) begin
        m[k] = 1'b1;
        if ((x & 3) == 3) begin s[k] = 1'b1; x = x + 1; end
        else x = x - 1;
      end
      x = x >>> 1;
    end
    return {s, m};
  endfunction

  function automatic longint sum_digits(input logic [63:0] s, input logic [63:0] m, input int n);
    longint acc;
    acc = 0;
    for (int k = 0; k < n; k++)
      if (m[k]) acc = s[k] ? acc - (longint'(1) << k) : acc + (longint'(1) << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_props(input string tag, input logic [63:0] s, input logic [63:0] m,
                             input int n, input longint val);
    check({tag, " R1 legal code"}, 128'(s & ~m), 128'(0));
    check({tag, " R4 no adjacent"}, 128'(m & (m >> 1)), 128'(0));
    check({tag, " R5 value"}, 128'(sum_digits(s, m, n)), 128'(val));
  endtask

  task automatic apply_small(input logic [NW-1:0] v);
    logic [127:0] es, eu;
    longint sv, uv;
    @(negedge clk);
    bin_s = v; bin_u = v;
    @(negedge clk);
    sv = longint'($signed(v));
    uv = longint'(v);
    es = ref_csd(sv);
    eu = ref_csd(uv);
    check("R2 R3 signed digits", {64'(s_sign), 64'(s_mag)},
          {64'(es[64 +: NW]), 64'(es[0 +: NW])});
    check("R7 unsigned digits", {64'(u_sign), 64'(u_mag)},
          {64'(eu[64 +: NW+1]), 64'(eu[0 +: NW+1])});
    check_props("signed", 64'(s_sign), 64'(s_mag), NW, sv);
    check_props("unsigned", 64'(u_sign), 64'(u_mag), NW+1, uv);
  endtask

  task automatic apply_wide(input logic [WW-1:0] v);
    logic [127:0] e;
    longint sv;
    @(negedge clk);
    bin_w = v;
    @(negedge clk);
    sv = longint'($signed(v));
    e = ref_csd(sv);
    check("R6 wide digits", {64'(w_sign), 64'(w_mag)},
          {64'(e[64 +: WW]), 64'(e[0 +: WW])});
    check_props("wide", 64'(w_sign), 64'(w_mag), WW, sv);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    bin_s = 8'hA5; bin_u = 8'h5A; bin_w = 32'hFFFF_0001;
    repeat (3) @(negedge clk);
    // R8: reset clears outputs
    check("R8 reset signed", {64'(s_sign), 64'(s_mag)}, 128'(0));
    check("R8 reset unsigned", {64'(u_sign), 64'(u_mag)}, 128'(0));
    rst_n = 1'b1;

    // R8: one cycle latency: value appears after the first posedge
    @(negedge clk);
    bin_s = 8'h01;
    @(posedge clk); #1;
    check("R8 latency", {64'(s_sign), 64'(s_mag)}, {64'(0), 64'(1)});

    // R9: 0101011 -> +1 0 -1 0 -1 0 -1
    apply_small(8'b0010_1011);
    check("R9 example mag", 128'(s_mag[6:0]), 128'(7'b1010101));
    check("R9 example sign", 128'(s_sign[6:0]), 128'(7'b0010101));

    // R6: all ones -> single -1 at position 0
    apply_small(8'hFF);
    check("R6 all ones", {64'(s_sign), 64'(s_mag)}, {64'(1), 64'(1)});

    // R7: 2^n-1 unsigned -> +1 at n, -1 at 0
    check("R7 max unsigned", {64'(u_sign), 64'(u_mag)}, {64'(1), 64'(9'h101)});

    // R3: alternating pattern, bypass must suppress every other digit
    apply_small(8'b0101_0101);
    check("R3 alternating mag", 128'(s_mag), 128'(8'b0101_0101));

    // R2: isolated window 010 at slice 2 gives +1 there
    apply_small(8'b0000_0100);
    check("R2 isolated plus", {64'(s_sign), 64'(s_mag)}, {64'(0), 64'(8'b0000_0100)});

    // R2: run 0110 gives -1 at start and +1 above the run
    apply_small(8'b0000_0110);
    check("R2 run of two", {64'(s_sign), 64'(s_mag)}, {64'(8'b0000_0010), 64'(8'b0000_1010)});

    // R6: most negative
    apply_small(8'h80);
    check("R6 most negative", {64'(s_sign), 64'(s_mag)}, {64'(8'h80), 64'(8'h80)});

    // exhaustive small width: R2 R3 R4 R5 R7
    for (int v = 0; v < 256; v++) apply_small(8'(v));

    // wide random plus corners: R5 R6
    apply_wide(32'h5555_5555);
    apply_wide(32'h7FFF_FFFF);
    apply_wide(32'h8000_0000);
    apply_wide(32'hAAAA_AAAB);
    for (int k = 0; k < 3000; k++) apply_wide($urandom);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule